// File: doc/BRIEF.md
# Indexed Configuration Register Space for a Multi-Function I/O Controller

This block is the configuration space of a multi-function I/O controller. A host reaches it through two byte-wide ports: a write to port offset 0 loads an index latch, and an access to port offset 1 reads or writes the register that the latch points at. A few registers are global: a fixed identification byte, a revision byte, a logical-device selector and a small set of general configuration bytes. Others are banked, so one index reaches a different physical register for each logical device, depending on the current selector value.

Each logical device owns an enable flag and a 16-bit I/O base address. The block drives all of them continuously on its outputs so that an external address decoder can steer host cycles to the devices without going through the index/data pair. Reads return the addressed register combinationally. Writes take effect at the next rising clock edge.

Top module: `sio_cfg_space`

## Requirements
- R1: A write at port offset 0 loads the index latch with the written byte. A read at offset 0 returns the latch value.
- R2: Index 0x20 reads the chip identification byte 0xE9 and index 0x27 reads the revision byte (default 0x02). Writes to either index leave both values unchanged.
- R3: Index 0x07 is the logical-device selector. A write of 0x00 to 0x0E (15 devices) is stored, and a read returns it.
- R4: A write to index 0x07 with a value above 0x0E is ignored, and the earlier selection is kept.
- R5: Index 0x30 reaches the enable flag of the selected device. Written bit 0 becomes the flag, a read returns 0x01 when the flag is set and 0x00 when it is clear, and no other device changes.
- R6: Index 0x60 reaches bits 15:8 and index 0x61 reaches bits 7:0 of the selected device's base address. Only the selected device changes.
- R7: Indices 0x21 to 0x25, 0x28 and 0x2A to 0x2D are read/write bytes shared by all devices, so a value written there reads back the same under any selection.
- R8: Every other index reads 0x00, and writes to it change no readable state.
- R9: After reset the index latch, the selector, every enable flag, every base address and every global configuration byte are zero.
- R10: `devActive[d]` and `devBase[16*d +: 16]` show device d's enable flag and base address, and they update at the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 1 | Port offset: 0 selects the index latch, 1 selects data |
| hostWr | input | 1 | Write strobe for the current cycle |
| hostWrData | input | 8 | Write byte |
| hostRdData | output | 8 | Read byte for the port addressed by hostAddr |
| devActive | output | 15 | Enable flag of each logical device |
| devBase | output | 240 | 16-bit base address of each device, device d at bits 16*d+15:16*d |

## Verification
A wrong selector is the most dangerous internal fault. It sends banked reads and writes to another device. That device's bits on `devActive` or `devBase` then change in the cycle after the write, where the unselected devices should have held still. A corrupted index latch shows at once on an offset-0 read and on the next data read. A global byte that is wrongly banked shows when the bench reads it back after changing the selector. Comparing every cycle pins each fault to the first edge where it appears.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IDX_LDN = 8'h07;
  localparam logic [7:0] IDX_ID  = 8'h20;
  localparam logic [7:0] IDX_REV = 8'h27;
  localparam logic [7:0] IDX_ACT = 8'h30;
  localparam logic [7:0] IDX_BHI = 8'h60;
  localparam logic [7:0] IDX_BLO = 8'h61;

  // implemented shared bytes within 0x20..0x2F, bit n => index 0x20+n
  localparam logic [15:0] GLOB_MASK = 16'h3D3E;

  typedef enum logic [3:0] {
    RD_IDX, RD_ID, RD_REV, RD_LDN, RD_ACT, RD_BHI, RD_BLO, RD_GLOB, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic       ldnWr;
    logic       actWr;
    logic       baseHiWr;
    logic       baseLoWr;
    logic       globWr;
    logic [3:0] globSel;
    rdSel_e     rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddr,
  input  logic       hostWr,
  input  logic [7:0] hostWrData,
  output logic [7:0] curIdx,
  output cfgStrobe_t strb
);

  localparam logic [7:0] LDN_LIMIT = 8'(NUM_DEV);

  logic [7:0] idxQ;
  logic       dataWr;
  logic       isGlob;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (hostWr && !hostAddr) begin
      idxQ <= hostWrData;
    end
  end

  assign curIdx = idxQ;
  assign dataWr = hostWr && hostAddr;
  assign isGlob = (idxQ[7:4] == 4'h2) && GLOB_MASK[idxQ[3:0]];

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    strb.globSel = idxQ[3:0];

    if (!hostAddr) begin
      strb.rdSel = RD_IDX;
    end else begin
      case (idxQ)
        IDX_ID:  strb.rdSel = RD_ID;
        IDX_REV: strb.rdSel = RD_REV;
        IDX_LDN: strb.rdSel = RD_LDN;
        IDX_ACT: strb.rdSel = RD_ACT;
        IDX_BHI: strb.rdSel = RD_BHI;
        IDX_BLO: strb.rdSel = RD_BLO;
        default: strb.rdSel = isGlob ? RD_GLOB : RD_ZERO;
      endcase
    end

    strb.ldnWr    = dataWr && (idxQ == IDX_LDN) && (hostWrData < LDN_LIMIT);
    strb.actWr    = dataWr && (idxQ == IDX_ACT);
    strb.baseHiWr = dataWr && (idxQ == IDX_BHI);
    strb.baseLoWr = dataWr && (idxQ == IDX_BLO);
    strb.globWr   = dataWr && isGlob;
  end

endmodule

// File: rtl/sio_cfg_dpath.sv
module sio_cfg_dpath
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_DEV = 15,
  parameter int         DEV_W   = 4,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h02
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strb,
  input  logic [7:0]              curIdx,
  input  logic [7:0]              hostWrData,
  output logic [7:0]              hostRdData,
  output logic [DEV_W-1:0]        curLdn,
  output logic [NUM_DEV-1:0]      devActive,
  output logic [NUM_DEV*16-1:0]   devBase
);

  localparam int GLOB_N = 16;

  logic [DEV_W-1:0]             ldnQ;
  logic [NUM_DEV-1:0]           actVal;
  logic [NUM_DEV-1:0][15:0]     baseVal;
  logic [GLOB_N-1:0][7:0]       globVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldnQ <= '0;
    end else if (strb.ldnWr) begin
      ldnQ <= hostWrData[DEV_W-1:0];
    end
  end

  // one bank of per-device state
  for (genvar d = 0; d < NUM_DEV; d++) begin : gDev
    logic        actQ;
    logic [15:0] baseQ;
    logic        sel;

    assign sel = (ldnQ == DEV_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actQ  <= 1'b0;
        baseQ <= '0;
      end else begin
        if (strb.actWr && sel)    actQ        <= hostWrData[0];
        if (strb.baseHiWr && sel) baseQ[15:8] <= hostWrData;
        if (strb.baseLoWr && sel) baseQ[7:0]  <= hostWrData;
      end
    end

    assign actVal[d]  = actQ;
    assign baseVal[d] = baseQ;
  end

  // shared configuration bytes, only where the mask marks one
  for (genvar g = 0; g < GLOB_N; g++) begin : gGlob
    if (GLOB_MASK[g]) begin : gImpl
      logic [7:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ <= '0;
        end else if (strb.globWr && (strb.globSel == 4'(g))) begin
          regQ <= hostWrData;
        end
      end
      assign globVal[g] = regQ;
    end else begin : gNone
      assign globVal[g] = '0;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_IDX:  hostRdData = curIdx;
      RD_ID:   hostRdData = CHIP_ID;
      RD_REV:  hostRdData = REV_ID;
      RD_LDN:  hostRdData = 8'(ldnQ);
      RD_ACT:  hostRdData = {7'b0, actVal[ldnQ]};
      RD_BHI:  hostRdData = baseVal[ldnQ][15:8];
      RD_BLO:  hostRdData = baseVal[ldnQ][7:0];
      RD_GLOB: hostRdData = globVal[strb.globSel];
      default: hostRdData = 8'h00;
    endcase
  end

  assign curLdn    = ldnQ;
  assign devActive = actVal;
  assign devBase   = baseVal;

endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_DEV = 15,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h02
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostAddr,
  input  logic                  hostWr,
  input  logic [7:0]            hostWrData,
  output logic [7:0]            hostRdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase
);

  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  cfgStrobe_t       strb;
  logic [7:0]       curIdx;
  logic [DEV_W-1:0] curLdn;

  sio_cfg_ctrl #(.NUM_DEV(NUM_DEV)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostWrData (hostWrData),
    .curIdx     (curIdx),
    .strb       (strb)
  );

  sio_cfg_dpath #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W),
    .CHIP_ID (CHIP_ID),
    .REV_ID  (REV_ID)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .curIdx     (curIdx),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .curLdn     (curLdn),
    .devActive  (devActive),
    .devBase    (devBase)
  );

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int         NUM_DEV = 15,
  parameter int         DEV_W   = 4,
  parameter logic [7:0] CHIP_ID = 8'hE9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  hostAddr,
  input logic                  hostWr,
  input logic [7:0]            hostWrData,
  input logic [7:0]            hostRdData,
  input logic [7:0]            curIdx,
  input logic [DEV_W-1:0]      curLdn,
  input logic [NUM_DEV-1:0]    devActive,
  input logic [NUM_DEV*16-1:0] devBase
);

  localparam int LDN_MAX = NUM_DEV - 1;

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr) |=> (curIdx == $past(hostWrData))); // R1

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr && curIdx == 8'h20) |-> (hostRdData == CHIP_ID)); // R2

  AST_LDN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(curLdn) <= LDN_MAX)); // R4

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostAddr && curIdx == 8'h30) |=> $stable(devActive)); // R5

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostAddr && (curIdx == 8'h60 || curIdx == 8'h61))
      |=> $stable(devBase)); // R6

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr && (curIdx == 8'h26 || curIdx == 8'h40 || curIdx == 8'hFF))
      |-> (hostRdData == 8'h00)); // R8

  AST_ONE_ENABLE_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(devActive ^ $past(devActive)) <= 1)); // R5

endmodule

bind sio_cfg_space sio_cfg_checker #(
  .NUM_DEV (NUM_DEV),
  .DEV_W   (DEV_W),
  .CHIP_ID (CHIP_ID)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostWr     (hostWr),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .curIdx     (curIdx),
  .curLdn     (curLdn),
  .devActive  (devActive),
  .devBase    (devBase)
);

// File: tb/tb_sio_cfg_space.sv
module tb_sio_cfg_space;

  localparam int NDEV = 15;

  logic             clk;
  logic             rstN;
  logic             hostAddr;
  logic             hostWr;
  logic [7:0]       hostWrData;
  logic [7:0]       hostRdData;
  logic [NDEV-1:0]  devActive;
  logic [NDEV*16-1:0] devBase;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int mIdx;
  int mLdn;
  bit mAct [NDEV];
  int mBase [NDEV];
  int mGlob [16];

  sio_cfg_space dut (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .devActive  (devActive),
    .devBase    (devBase)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit isShared(int i);
    case (i)
      'h21, 'h22, 'h23, 'h24, 'h25, 'h28, 'h2A, 'h2B, 'h2C, 'h2D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int modelRead(bit a);
    if (!a) return mIdx;
    if (mIdx == 'h20) return 'hE9;
    if (mIdx == 'h27) return 'h02;
    if (mIdx == 'h07) return mLdn;
    if (mIdx == 'h30) return mAct[mLdn] ? 1 : 0;
    if (mIdx == 'h60) return (mBase[mLdn] >> 8) & 'hFF;
    if (mIdx == 'h61) return mBase[mLdn] & 'hFF;
    if (isShared(mIdx)) return mGlob[mIdx - 'h20];
    return 0;
  endfunction

  task automatic modelWrite(bit a, int d);
    if (!a) begin
      mIdx = d;
    end else if (mIdx == 'h07) begin
      if (d <= 'h0E) mLdn = d;
    end else if (mIdx == 'h30) begin
      mAct[mLdn] = d[0];
    end else if (mIdx == 'h60) begin
      mBase[mLdn] = (d << 8) | (mBase[mLdn] & 'hFF);
    end else if (mIdx == 'h61) begin
      mBase[mLdn] = (mBase[mLdn] & 'hFF00) | d;
    end else if (isShared(mIdx)) begin
      mGlob[mIdx - 'h20] = d;
    end
  endtask

  task automatic modelReset();
    mIdx = 0;
    mLdn = 0;
    for (int i = 0; i < NDEV; i++) begin
      mAct[i]  = 1'b0;
      mBase[i] = 0;
    end
    for (int i = 0; i < 16; i++) mGlob[i] = 0;
  endtask

  task automatic compareAll(string tag);
    logic [NDEV-1:0]    expAct;
    logic [NDEV*16-1:0] expBase;
    int expRd;
    expRd = modelRead(hostAddr);
    checks++;
    if (hostRdData !== 8'(expRd)) begin
      errors++;
      $display("FAIL %s read idx=%02h addr=%0b actual=%02h expected=%02h",
               tag, mIdx, hostAddr, hostRdData, expRd);
    end
    for (int i = 0; i < NDEV; i++) begin
      expAct[i]           = mAct[i];
      expBase[16*i +: 16] = 16'(mBase[i]);
    end
    checks++;
    if (devActive !== expAct || devBase !== expBase) begin
      errors++;
      $display("FAIL R10 (%s) exports actual=%h/%h expected=%h/%h",
               tag, devActive, devBase, expAct, expBase);
    end
  endtask

  // one host cycle: drive at negedge, compare before the edge, update model at edge
  task automatic step(bit a, bit w, int d, string tag);
    @(negedge clk);
    hostAddr   = a;
    hostWr     = w;
    hostWrData = 8'(d);
    #1;
    compareAll(tag);
    @(posedge clk);
    if (w) modelWrite(a, d);
  endtask

  task automatic wrReg(int idx, int d, string tag);
    step(1'b0, 1'b1, idx, tag);
    step(1'b1, 1'b1, d, tag);
  endtask

  task automatic rdReg(int idx, string tag);
    step(1'b0, 1'b1, idx, tag);
    step(1'b1, 1'b0, 0, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    hostAddr = 1'b0; hostWr = 1'b0; hostWrData = '0;
    rstN = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    step(1'b0, 1'b0, 0, "R9");
    rdReg('h07, "R9");
    rdReg('h30, "R9");
    rdReg('h60, "R9");
    rdReg('h2D, "R9");

    // R1: index latch
    step(1'b0, 1'b1, 'hA7, "R1");
    step(1'b0, 1'b0, 0, "R1");
    step(1'b0, 1'b1, 'h00, "R1");
    step(1'b0, 1'b0, 0, "R1");

    // R2: identification and revision are fixed
    rdReg('h20, "R2");
    wrReg('h20, 'h55, "R2");
    step(1'b1, 1'b0, 0, "R2");
    rdReg('h27, "R2");
    wrReg('h27, 'hFF, "R2");
    step(1'b1, 1'b0, 0, "R2");

    // R3 / R4: selector
    wrReg('h07, 'h03, "R3");
    step(1'b1, 1'b0, 0, "R3");
    wrReg('h07, 'h0F, "R4");
    step(1'b1, 1'b0, 0, "R4");
    wrReg('h07, 'hFF, "R4");
    step(1'b1, 1'b0, 0, "R4");
    wrReg('h07, 'h0E, "R3");
    step(1'b1, 1'b0, 0, "R3");

    // R5 / R6 on the top device
    wrReg('h30, 'hFF, "R5");
    step(1'b1, 1'b0, 0, "R5");
    wrReg('h60, 'hBE, "R6");
    wrReg('h61, 'hEF, "R6");
    rdReg('h60, "R6");

    // R5 / R6 on device 3, then back to check isolation
    wrReg('h07, 'h03, "R3");
    rdReg('h30, "R5");
    wrReg('h30, 'h01, "R5");
    wrReg('h61, 'h80, "R6");
    wrReg('h60, 'h03, "R6");
    rdReg('h61, "R6");
    wrReg('h07, 'h0E, "R6");
    rdReg('h61, "R6");
    wrReg('h30, 'hFE, "R5");
    step(1'b1, 1'b0, 0, "R5");
    wrReg('h07, 'h00, "R3");
    rdReg('h30, "R5");
    rdReg('h60, "R6");

    // R7: shared bytes are not banked
    wrReg('h21, 'hA5, "R7");
    wrReg('h28, 'h3C, "R7");
    wrReg('h2D, 'h81, "R7");
    wrReg('h25, 'h7E, "R7");
    wrReg('h2A, 'h11, "R7");
    wrReg('h07, 'h09, "R7");
    rdReg('h21, "R7");
    rdReg('h28, "R7");
    rdReg('h2D, "R7");
    rdReg('h25, "R7");
    rdReg('h2A, "R7");

    // R8: unimplemented indices
    wrReg('h26, 'hFF, "R8");
    step(1'b1, 1'b0, 0, "R8");
    wrReg('h29, 'h12, "R8");
    step(1'b1, 1'b0, 0, "R8");
    wrReg('h31, 'h01, "R8");
    step(1'b1, 1'b0, 0, "R8");
    wrReg('hFF, 'h77, "R8");
    step(1'b1, 1'b0, 0, "R8");
    rdReg('h2E, "R8");

    // R9: reset mid-run clears everything again
    @(negedge clk);
    hostWr = 1'b0;
    rstN   = 1'b0;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0, 0, "R9");
    rdReg('h21, "R9");
    wrReg('h07, 'h03, "R9");
    rdReg('h30, "R9");

    step(1'b0, 1'b0, 0, "R10");
    finishRun();
  end

endmodule